// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns an interrupt command into the set of processor cores that must receive it. A request carries two 32-bit command words and the index of the sending core. The block reads the destination byte, the destination mode and the 2-bit shorthand from the command. It matches them against a small table that holds, for each core, a physical ID, an 8-bit logical destination, a 4-bit destination model and a present flag. The result is a registered bitmask with one bit per core, plus a one-cycle strobe.

The block also serves lowest-priority delivery. In that mode the mask is cut down to the lowest-indexed candidate, and that core's index is reported. There is no real priority arbitration. The vector, delivery mode, level and trigger bits are passed along with the mask so that a downstream signalling stage can act on them. The core table is loaded through a small write port that takes the same field positions as the per-core configuration registers.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset `out_valid` is 0 and `out_mask` is 0. Every core then has physical ID equal to its index, logical destination 0x00, destination model 0xF and the present flag set.
- R2: Shorthand sits in `cmd_lo[19:18]`. A value of 0 uses the destination field. 1 selects only core `req_src`. 2 selects every core. 3 selects every core except `req_src`.
- R3: With shorthand 0 and destination mode 0 (`cmd_lo[11]`), destination `cmd_hi[31:24]` = 0xFF selects every core. Any other value selects the cores whose physical ID equals it.
- R4: In logical mode (`cmd_lo[11]`=1), a core with model 0xF matches when destination AND logical destination is nonzero.
- R5: In logical mode, a core with model 0x0 matches when the upper nibbles of destination and logical destination are equal and their lower nibbles share a set bit. A core with any other model never matches.
- R6: With delivery mode 1 (`cmd_lo[10:8]`), the mask holds only the lowest-indexed candidate, and `out_target` gives that index.
- R7: `out_vector`, `out_deliv`, `out_level` and `out_trig` carry `cmd_lo[7:0]`, `[10:8]`, `[14]` and `[15]` of the request.
- R8: A table write selects its field with `cfg_sel`. 0 sets the physical ID from `cfg_data[31:24]`. 1 sets the logical destination from `cfg_data[31:24]`. 2 sets the model from `cfg_data[31:28]`. 3 sets the present flag from `cfg_data[0]`. The new value applies to requests from the next cycle on.
- R9: A request whose resulting mask is empty gives no strobe.
- R10: A core whose present flag is clear is never selected, not even by broadcast or self shorthand.
- R11: Results appear one clock after `req_valid`, with `out_valid` high for exactly that cycle. Back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write enable |
| cfg_core | input | IDX_W | Core entry to write |
| cfg_sel | input | 2 | Field select for the write |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | IDX_W | Index of the sending core |
| cmd_lo | input | 32 | Low command word |
| cmd_hi | input | 32 | High command word (destination in 31:24) |
| out_valid | output | 1 | Delivery strobe |
| out_mask | output | NUM_CORES | Target cores |
| out_target | output | IDX_W | Lowest set index of the mask |
| out_vector | output | 8 | Vector of the request |
| out_deliv | output | 3 | Delivery mode of the request |
| out_level | output | 1 | Level bit of the request |
| out_trig | output | 1 | Trigger bit of the request |

## Verification
The bench compares each request against a scoreboard model that tracks its own copy of the core table. It targets a physical ID that no core holds. A design that matched on a partial ID, or strobed anyway, would emit a spurious delivery. Cluster mode is tested with a destination whose lower nibble overlaps but whose cluster differs, to catch a resolver that ignores the upper nibble. A core with an unsupported model is also covered, to catch a design that treats every non-flat model as cluster. Absent cores are combined with broadcast, self and lowest-priority requests, so a design that applies presence only on the physical path would leak a bit or choose the wrong lowest target.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int DEST_W = 8;
  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [2:0] DELIV_LOWEST  = 3'd1;
  localparam logic [DEST_W-1:0] DEST_BCAST = 8'hFF;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    CFG_PHYS    = 2'd0,
    CFG_LOGICAL = 2'd1,
    CFG_MODEL   = 2'd2,
    CFG_PRESENT = 2'd3
  } cfg_sel_e;

  // logical-mode hit for one core
  function automatic logic logical_hit(input logic [DEST_W-1:0] dest,
                                       input logic [DEST_W-1:0] ldest,
                                       input logic [3:0] model);
    logic hit;
    hit = 1'b0;
    if (model == MODEL_FLAT)
      hit = |(dest & ldest);
    else if (model == MODEL_CLUSTER)
      hit = (dest[7:4] == ldest[7:4]) && |(dest[3:0] & ldest[3:0]);
    return hit;
  endfunction

  // physical-mode hit for one core
  function automatic logic physical_hit(input logic [DEST_W-1:0] dest,
                                        input logic [DEST_W-1:0] pid);
    return (dest == DEST_BCAST) || (dest == pid);
  endfunction
endpackage

// File: rtl/irq_core_table.sv
module irq_core_table
  import irq_dest_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [IDX_W-1:0]                  cfg_core,
  input  logic [1:0]                        cfg_sel,
  input  logic [31:0]                       cfg_data,
  output logic [NUM_CORES-1:0][DEST_W-1:0]  tbl_pid,
  output logic [NUM_CORES-1:0][DEST_W-1:0]  tbl_ldest,
  output logic [NUM_CORES-1:0][3:0]         tbl_model,
  output logic [NUM_CORES-1:0]              tbl_present
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_entry
    logic hit_w;
    assign hit_w = cfg_we && (cfg_core == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl_pid[i]     <= DEST_W'(i);
        tbl_ldest[i]   <= '0;
        tbl_model[i]   <= MODEL_FLAT;
        tbl_present[i] <= 1'b1;
      end else if (hit_w) begin
        case (cfg_sel_e'(cfg_sel))
          CFG_PHYS:    tbl_pid[i]     <= cfg_data[31:24];
          CFG_LOGICAL: tbl_ldest[i]   <= cfg_data[31:24];
          CFG_MODEL:   tbl_model[i]   <= cfg_data[31:28];
          default:     tbl_present[i] <= cfg_data[0];
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_core_match.sv
module irq_core_match
  import irq_dest_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [DEST_W-1:0]                 dest,
  input  logic                              logical_mode,
  input  logic [1:0]                        shorthand,
  input  logic [IDX_W-1:0]                  src,
  input  logic [NUM_CORES-1:0][DEST_W-1:0]  tbl_pid,
  input  logic [NUM_CORES-1:0][DEST_W-1:0]  tbl_ldest,
  input  logic [NUM_CORES-1:0][3:0]         tbl_model,
  input  logic [NUM_CORES-1:0]              tbl_present,
  output logic [NUM_CORES-1:0]              cand
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic is_src, field_hit, sel;
    assign is_src    = (src == IDX_W'(i));
    assign field_hit = logical_mode ? logical_hit(dest, tbl_ldest[i], tbl_model[i])
                                    : physical_hit(dest, tbl_pid[i]);
    always_comb begin
      case (shorthand_e'(shorthand))
        SH_FIELD: sel = field_hit;
        SH_SELF:  sel = is_src;
        SH_ALL:   sel = 1'b1;
        default:  sel = !is_src;
      endcase
    end
    assign cand[i] = sel && tbl_present[i];
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_CORES = 8,
  parameter int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0] mask,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_CORES-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--)
      if (mask[i]) idx = IDX_W'(i);
    onehot = '0;
    if (|mask) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_core,
  input  logic [1:0]            cfg_sel,
  input  logic [31:0]           cfg_data,
  input  logic                  req_valid,
  input  logic [IDX_W-1:0]      req_src,
  input  logic [31:0]           cmd_lo,
  input  logic [31:0]           cmd_hi,
  output logic                  out_valid,
  output logic [NUM_CORES-1:0]  out_mask,
  output logic [IDX_W-1:0]      out_target,
  output logic [7:0]            out_vector,
  output logic [2:0]            out_deliv,
  output logic                  out_level,
  output logic                  out_trig
);
  logic [NUM_CORES-1:0][DEST_W-1:0] tbl_pid, tbl_ldest;
  logic [NUM_CORES-1:0][3:0]        tbl_model;
  logic [NUM_CORES-1:0]             present_vec;
  logic [NUM_CORES-1:0]             cand_mask, low_onehot, final_mask;
  logic [IDX_W-1:0]                 low_idx;
  logic [DEST_W-1:0]                f_dest;
  logic [2:0]                       f_deliv;
  logic [1:0]                       f_short;
  logic                             f_logical, lowest_mode;
  logic                             unused_bits;

  assign f_dest      = cmd_hi[31:24];
  assign f_deliv     = cmd_lo[10:8];
  assign f_logical   = cmd_lo[11];
  assign f_short     = cmd_lo[19:18];
  assign lowest_mode = (f_deliv == DELIV_LOWEST);
  assign unused_bits = ^{cmd_lo[31:20], cmd_lo[17:16], cmd_lo[13:12],
                         cmd_hi[23:0], cfg_data[23:1]};

  irq_core_table #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_core(cfg_core),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .tbl_pid(tbl_pid),
    .tbl_ldest(tbl_ldest), .tbl_model(tbl_model), .tbl_present(present_vec)
  );

  irq_core_match #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_match (
    .dest(f_dest), .logical_mode(f_logical), .shorthand(f_short),
    .src(req_src), .tbl_pid(tbl_pid), .tbl_ldest(tbl_ldest),
    .tbl_model(tbl_model), .tbl_present(present_vec), .cand(cand_mask)
  );

  irq_lowest_pick #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_pick (
    .mask(cand_mask), .idx(low_idx), .onehot(low_onehot)
  );

  assign final_mask = lowest_mode ? low_onehot : cand_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_mask   <= '0;
      out_target <= '0;
      out_vector <= '0;
      out_deliv  <= '0;
      out_level  <= 1'b0;
      out_trig   <= 1'b0;
    end else begin
      out_valid <= req_valid && (|final_mask);
      out_mask  <= req_valid ? final_mask : '0;
      if (req_valid) begin
        out_target <= low_idx;
        out_vector <= cmd_lo[7:0];
        out_deliv  <= f_deliv;
        out_level  <= cmd_lo[14];
        out_trig   <= cmd_lo[15];
      end
    end
  end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int NUM_CORES = 8,
  parameter int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [IDX_W-1:0]     req_src,
  input logic [31:0]          cmd_lo,
  input logic                 out_valid,
  input logic [NUM_CORES-1:0] out_mask,
  input logic [IDX_W-1:0]     out_target,
  input logic [2:0]           out_deliv,
  input logic [NUM_CORES-1:0] present_vec
);
  AST_NO_EMPTY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0)); // R9
  AST_ABSENT_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & ~$past(present_vec)) == '0)); // R10
  AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_deliv == 3'd1) |-> ($countones(out_mask) == 1)); // R6
  AST_LOWEST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_deliv == 3'd1) |-> out_mask[out_target]); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(req_valid)); // R11
  AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cmd_lo[19:18] == 2'd1)) |->
      (out_mask == (NUM_CORES'(1) << $past(req_src)))); // R2
  AST_OTHERS_SKIP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cmd_lo[19:18] == 2'd3)) |-> !out_mask[$past(req_src)]); // R2
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
  .cmd_lo(cmd_lo), .out_valid(out_valid), .out_mask(out_mask),
  .out_target(out_target), .out_deliv(out_deliv), .present_vec(present_vec)
);

// File: tb/irq_dest_resolver_test.sv
`timescale 1ns/1ps
module irq_dest_resolver_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_core = '0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic req_valid = 1'b0;
  logic [IW-1:0] req_src = '0;
  logic [31:0] cmd_lo = '0, cmd_hi = '0;
  logic out_valid, out_level, out_trig;
  logic [N-1:0] out_mask;
  logic [IW-1:0] out_target;
  logic [7:0] out_vector;
  logic [2:0] out_deliv;

  irq_dest_resolver #(.NUM_CORES(N), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_core(cfg_core),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_src(req_src), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .out_valid(out_valid), .out_mask(out_mask), .out_target(out_target),
    .out_vector(out_vector), .out_deliv(out_deliv), .out_level(out_level),
    .out_trig(out_trig)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit done = 0, started = 0;

  // bench copy of the core table
  logic [7:0] m_pid [N];
  logic [7:0] m_ld  [N];
  logic [3:0] m_md  [N];
  bit         m_pr  [N];

  typedef struct {
    int          due;
    string       tag;
    bit          valid;
    logic [N-1:0] mask;
    int          target;
    bit          lowest;
    logic [7:0]  vec;
    logic [2:0]  deliv;
    bit          level, trig;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_mask(input logic [7:0] dest, input bit lg,
                                              input int sh, input int src);
    logic [N-1:0] m = '0;
    for (int c = 0; c < N; c++) begin
      bit hit = 0;
      if (sh == 1) hit = (c == src);
      else if (sh == 2) hit = 1;
      else if (sh == 3) hit = (c != src);
      else if (!lg) hit = (dest == 8'hFF) || (m_pid[c] == dest);
      else if (m_md[c] == 4'hF) hit = (dest & m_ld[c]) != 0;
      else if (m_md[c] == 4'h0)
        hit = (dest[7:4] == m_ld[c][7:4]) && ((dest[3:0] & m_ld[c][3:0]) != 0);
      m[c] = hit && m_pr[c];
    end
    return m;
  endfunction

  task automatic send(input string tag, input int src, input logic [7:0] dest, input bit lg,
                      input int sh, input logic [2:0] deliv, input logic [7:0] vec,
                      input bit level, input bit trig);
    exp_t e;
    logic [N-1:0] m;
    @(negedge clk);
    req_valid = 1'b1;
    req_src   = IW'(src);
    cmd_lo    = {12'hABC, 2'(sh), 2'b11, trig, level, 2'b11, lg, deliv, vec};
    cmd_hi    = {dest, 24'h5A5A5A};
    m = model_mask(dest, lg, sh, src);
    e.lowest = (deliv == 3'd1);
    e.target = 0;
    if (m != 0) begin
      for (int c = N - 1; c >= 0; c--) if (m[c]) e.target = c;
      if (e.lowest) m = N'(1) << e.target;
    end
    e.due = cyc + 1; e.tag = tag; e.valid = (m != 0); e.mask = m;
    e.vec = vec; e.deliv = deliv; e.level = level; e.trig = trig;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg(input int core, input int sel, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_core = IW'(core); cfg_sel = 2'(sel); cfg_data = data;
    case (sel)
      0: m_pid[core] = data[31:24];
      1: m_ld[core]  = data[31:24];
      2: m_md[core]  = data[31:28];
      default: m_pr[core] = data[0];
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin : monitor
    exp_t e;
    if (started) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        chk(out_valid == e.valid, {e.tag, " R9 strobe"}, 32'(out_valid), 32'(e.valid));
        if (e.valid) begin
          chk(out_mask == e.mask, {e.tag, " mask"}, 32'(out_mask), 32'(e.mask));
          chk(out_vector == e.vec && out_deliv == e.deliv && out_level == e.level &&
              out_trig == e.trig, {e.tag, " R7 fields"},
              {out_vector, 5'b0, out_deliv, 7'b0, out_level, 7'b0, out_trig},
              {e.vec, 5'b0, e.deliv, 7'b0, e.level, 7'b0, e.trig});
          if (e.lowest)
            chk(int'(out_target) == e.target, {e.tag, " R6 target"}, 32'(out_target), 32'(e.target));
        end
      end else if (out_valid) begin
        chk(1'b0, "R11 unexpected strobe", 32'(out_mask), 32'h0);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    for (int c = 0; c < N; c++) begin
      m_pid[c] = 8'(c); m_ld[c] = 8'h00; m_md[c] = 4'hF; m_pr[c] = 1'b1;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_mask == '0, "R1 reset outputs", {31'b0, out_valid} | 32'(out_mask), 32'h0);
    started = 1;

    // physical mode, default ids equal index
    send("R3 phys id 3", 0, 8'h03, 0, 0, 3'd0, 8'h31, 0, 0); idle();
    send("R3 phys bcast", 2, 8'hFF, 0, 0, 3'd0, 8'h32, 1, 1); idle();
    send("R3 phys nomatch", 0, 8'h20, 0, 0, 3'd0, 8'h33, 0, 1); idle();
    cfg(5, 0, 32'h20FF_FFFF);
    send("R8 phys id rewrite", 0, 8'h20, 0, 0, 3'd0, 8'h34, 0, 0); idle();

    // logical flat: ldest of core c is 1<<c (low bits of data ignored)
    for (int c = 0; c < N; c++) cfg(c, 1, {8'(1 << c), 24'hFFFFFF});
    send("R4 flat 0x81", 1, 8'h81, 1, 0, 3'd0, 8'h40, 0, 0); idle();
    send("R4 flat none", 1, 8'h00, 1, 0, 3'd0, 8'h41, 0, 0); idle();

    // cluster on cores 2,3; unsupported model on core 6
    cfg(2, 2, 32'h0FFF_FFFF); cfg(3, 2, 32'h0FFF_FFFF);
    cfg(2, 1, 32'h3100_0000); cfg(3, 1, 32'h4200_0000);
    cfg(6, 2, 32'h5000_0000);
    send("R5 cluster 0x33", 0, 8'h33, 1, 0, 3'd0, 8'h50, 0, 0); idle();
    send("R5 cluster wrong upper", 0, 8'h52, 1, 0, 3'd0, 8'h51, 0, 0); idle();
    send("R5 odd model all bits", 0, 8'hFF, 1, 0, 3'd0, 8'h52, 1, 0); idle();

    // shorthand, back-to-back (R11)
    send("R2 self", 4, 8'h00, 0, 1, 3'd0, 8'h60, 0, 0);
    send("R2 all", 4, 8'h00, 0, 2, 3'd0, 8'h61, 0, 0);
    send("R2 others", 0, 8'hFF, 0, 3, 3'd0, 8'h62, 1, 1); idle();

    // absent core
    cfg(1, 3, 32'hFFFF_FFFE);
    send("R10 bcast absent", 0, 8'hFF, 0, 0, 3'd0, 8'h70, 0, 0); idle();
    send("R10 all absent", 0, 8'h00, 0, 2, 3'd0, 8'h71, 0, 0); idle();
    send("R10 self absent", 1, 8'h00, 0, 1, 3'd0, 8'h72, 0, 0); idle();

    // lowest priority
    send("R6 lowest flat 0xF0", 0, 8'hF0, 1, 0, 3'd1, 8'h80, 0, 0); idle();
    send("R6 lowest others", 0, 8'h00, 0, 3, 3'd1, 8'h81, 1, 1); idle();
    send("R6 lowest empty", 1, 8'h00, 0, 1, 3'd1, 8'h82, 0, 0); idle();

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R11 all results seen", 32'(q.size()), 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule